// File: doc/BRIEF.md
# Bit-Test Branch Target Unit

This block resolves a branch whose condition is a mask test on one memory byte, and it computes the address of the next instruction to execute. Decode logic supplies the byte that was read, an 8-bit mask, a selector for the clear-test or set-test form, the signed branch offset (short or long form), the 16-bit address of the branching instruction, its 4-bit page field and its length in bytes. One cycle after a start strobe, the unit returns a registered result with a valid strobe. The result holds the taken flag, the new 16-bit program counter and the new page field.

A taken branch lands at the instruction address plus a fixed pipeline bias of 6, plus the offset with its lowest bit cleared. A branch that is not taken falls through to the instruction address plus the instruction length. In both cases the counter and the page field together form one 20-bit address. A carry out of the counter advances the page, and a borrow retreats it, modulo 16.

Top module: `bit_branch_unit`

## Requirements
- R1: With test_set_i=0 (clear test), the branch is taken exactly when mem_byte_i AND mask_i equals zero.
- R2: With test_set_i=1 (set test), the branch is taken exactly when every bit that is 1 in mask_i is also 1 in mem_byte_i.
- R3: A mask of 8'h00 makes the branch taken under both test forms, whatever the memory byte.
- R4: With wide_off_i=0, the offset is offset_i[7:0] sign-extended, and offset_i[15:8] has no effect. With wide_off_i=1, the offset is offset_i[15:0] as a signed value.
- R5: Bit 0 of the selected offset is cleared before the add, so an odd offset rounds down (for example -3 becomes -4) and pc_o of a taken branch has the same parity as insn_addr_i.
- R6: A taken target is insn_addr_i + 6 + rounded offset. Offsets 8'h7F/8'h80 give displacements +132/-122, and 16'h7FFF/16'h8000 give +32772/-32762.
- R7: The target sum is taken over {page_i, insn_addr_i} as a 20-bit value. Exceeding 16'hFFFF increments the page, going below 0 decrements it, and the page wraps modulo 16 (15+1=0, 0-1=15).
- R8: A branch that is not taken yields {page_i, insn_addr_i} + insn_len_i (zero-extended), with the same page carry rule.
- R9: valid_o is 1 in exactly the cycle after each cycle with start_i=1. taken_o, pc_o and page_o change only on such edges and hold otherwise.
- R10: While rst_ni is low, valid_o, taken_o, pc_o and page_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate the inputs on this edge |
| mem_byte_i | input | 8 | Memory byte under test |
| mask_i | input | 8 | Bit mask |
| test_set_i | input | 1 | 0: branch if masked bits clear; 1: branch if masked bits set |
| wide_off_i | input | 1 | 0: 8-bit offset; 1: 16-bit offset |
| offset_i | input | 16 | Signed branch offset |
| insn_addr_i | input | 16 | Address of the branching instruction |
| page_i | input | 4 | Current page field |
| insn_len_i | input | 4 | Instruction length in bytes, used on fall-through |
| valid_o | output | 1 | Result strobe, one cycle after start_i |
| taken_o | output | 1 | Branch taken |
| pc_o | output | 16 | Next program counter |
| page_o | output | 4 | Next page field |

## Verification
The bench drives the extreme short and long offsets. A design that added the bias in the wrong place, or that failed to clear bit 0, would miss the +132 and +32772 displacements by a few bytes. Targets cross the 16-bit boundary upward and downward, including page 15 to 0 and page 0 to 15, which exposes a counter that wraps without touching the page or steps the page the wrong way. Other stimuli catch a mask test whose sense is inverted or that ignores the mask: an all-zero mask under both forms, and bytes that differ from the mask in one bit only. A short offset carrying a non-zero high byte catches sign extension taken from the wrong bit, and odd negative offsets catch rounding toward zero instead of down.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  localparam int unsigned BBR_DATA_W   = 8;
  localparam int unsigned BBR_ADDR_W   = 16;
  localparam int unsigned BBR_PAGE_W   = 4;
  localparam int unsigned BBR_SHORT_W  = 8;
  localparam int unsigned BBR_LONG_W   = 16;
  localparam int unsigned BBR_LEN_W    = 4;
  localparam int unsigned BBR_PIPE_BIAS = 6;
endpackage

// File: rtl/bbr_bit_test.sv
module bbr_bit_test #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] mem_byte_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              test_set_i,
  output logic              pass_o
);
  logic [DATA_W-1:0] miss;

  // a masked bit misses when it differs from the wanted level
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign miss[b] = mask_i[b] & (mem_byte_i[b] ^ test_set_i);
  end

  assign pass_o = ~|miss;
endmodule

// File: rtl/bbr_offset_norm.sv
module bbr_offset_norm #(
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned LONG_W  = 16,
  parameter int unsigned FULL_W  = 20
) (
  input  logic              wide_i,
  input  logic [LONG_W-1:0] offset_i,
  output logic [FULL_W-1:0] delta_o
);
  logic [FULL_W-1:0] short_ext;
  logic [FULL_W-1:0] long_ext;
  logic [FULL_W-1:0] sel;

  assign short_ext = {{(FULL_W-SHORT_W){offset_i[SHORT_W-1]}}, offset_i[SHORT_W-1:0]};
  assign long_ext  = {{(FULL_W-LONG_W){offset_i[LONG_W-1]}}, offset_i};
  assign sel       = wide_i ? long_ext : short_ext;
  // word alignment: drop bit 0
  assign delta_o   = {sel[FULL_W-1:1], 1'b0};
endmodule

// File: rtl/bbr_addr_step.sv
module bbr_addr_step #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 4,
  localparam int unsigned FULL_W = ADDR_W + PAGE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [FULL_W-1:0] delta_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAGE_W-1:0] page_o
);
  logic [FULL_W-1:0] sum;

  // page carry/borrow falls out of the full-width add
  assign sum    = {page_i, addr_i} + delta_i;
  assign addr_o = sum[ADDR_W-1:0];
  assign page_o = sum[FULL_W-1:ADDR_W];
endmodule

// File: rtl/bit_branch_unit.sv
module bit_branch_unit
  import bbr_pkg::*;
#(
  parameter int unsigned DATA_W    = BBR_DATA_W,
  parameter int unsigned ADDR_W    = BBR_ADDR_W,
  parameter int unsigned PAGE_W    = BBR_PAGE_W,
  parameter int unsigned SHORT_W   = BBR_SHORT_W,
  parameter int unsigned LONG_W    = BBR_LONG_W,
  parameter int unsigned LEN_W     = BBR_LEN_W,
  parameter int unsigned PIPE_BIAS = BBR_PIPE_BIAS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mem_byte_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              test_set_i,
  input  logic              wide_off_i,
  input  logic [LONG_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] insn_addr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [LEN_W-1:0]  insn_len_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int unsigned FULL_W = ADDR_W + PAGE_W;

  logic              pass_c;
  logic [FULL_W-1:0] off_c;
  logic [FULL_W-1:0] delta_c;
  logic [ADDR_W-1:0] next_pc_c;
  logic [PAGE_W-1:0] next_page_c;

  bbr_bit_test #(.DATA_W(DATA_W)) u_test (
    .mem_byte_i (mem_byte_i),
    .mask_i     (mask_i),
    .test_set_i (test_set_i),
    .pass_o     (pass_c)
  );

  bbr_offset_norm #(.SHORT_W(SHORT_W), .LONG_W(LONG_W), .FULL_W(FULL_W)) u_off (
    .wide_i   (wide_off_i),
    .offset_i (offset_i),
    .delta_o  (off_c)
  );

  // one shared adder: bias+offset when taken, length when falling through
  always_comb begin
    if (pass_c) delta_c = off_c + FULL_W'(PIPE_BIAS);
    else        delta_c = {{(FULL_W-LEN_W){1'b0}}, insn_len_i};
  end

  bbr_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .addr_i  (insn_addr_i),
    .page_i  (page_i),
    .delta_i (delta_c),
    .addr_o  (next_pc_c),
    .page_o  (next_page_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      taken_o <= 1'b0;
      pc_o    <= '0;
      page_o  <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        taken_o <= pass_c;
        pc_o    <= next_pc_c;
        page_o  <= next_page_c;
      end
    end
  end
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] mem_byte_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              test_set_i,
  input logic [ADDR_W-1:0] insn_addr_i,
  input logic [PAGE_W-1:0] page_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [PAGE_W-1:0] page_o
);
  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o); // R9
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(pc_o) && $stable(page_o) && $stable(taken_o))); // R9
  AST_CLEAR_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !test_set_i && ((mem_byte_i & mask_i) == '0)) |=> taken_o); // R1
  AST_SET_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && test_set_i && ((~mem_byte_i & mask_i) != '0)) |=> !taken_o); // R2
  AST_ZERO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mask_i == '0)) |=> taken_o); // R3
  AST_TAKEN_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o) |-> (pc_o[0] == $past(insn_addr_i[0]))); // R5
  AST_PAGE_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((page_o == $past(page_i)) || (page_o == $past(page_i) + PAGE_W'(1))
                 || (page_o == $past(page_i) - PAGE_W'(1)))); // R7
endmodule

bind bit_branch_unit bbr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_byte_i  (mem_byte_i),
  .mask_i      (mask_i),
  .test_set_i  (test_set_i),
  .insn_addr_i (insn_addr_i),
  .page_i      (page_i),
  .valid_o     (valid_o),
  .taken_o     (taken_o),
  .pc_o        (pc_o),
  .page_o      (page_o)
);

// File: tb/tb_bit_branch_unit.sv
module tb_bit_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  mem_byte_i = '0;
  logic [7:0]  mask_i = '0;
  logic        test_set_i = 1'b0;
  logic        wide_off_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic [15:0] insn_addr_i = '0;
  logic [3:0]  page_i = '0;
  logic [3:0]  insn_len_i = '0;
  logic        valid_o;
  logic        taken_o;
  logic [15:0] pc_o;
  logic [3:0]  page_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  bit        m_taken;
  int        m_pc;
  int        m_page;

  bit_branch_unit dut (
    .clk_i, .rst_ni, .start_i, .mem_byte_i, .mask_i, .test_set_i, .wide_off_i,
    .offset_i, .insn_addr_i, .page_i, .insn_len_i, .valid_o, .taken_o, .pc_o, .page_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic void model();
    int off, full, delta;
    if (test_set_i) m_taken = ((~mem_byte_i) & mask_i) == 8'h00;
    else            m_taken = (mem_byte_i & mask_i) == 8'h00;
    if (wide_off_i) off = int'($signed(offset_i));
    else            off = int'($signed(offset_i[7:0]));
    off = off & ~1;
    delta = m_taken ? off + 6 : int'(insn_len_i);
    full = int'(page_i) * 65536 + int'(insn_addr_i) + delta;
    full = ((full % 1048576) + 1048576) % 1048576;
    m_pc = full % 65536;
    m_page = full / 65536;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one evaluation, then check result and one idle cycle of hold
  task automatic vec(input string tag, input logic [7:0] mem, input logic [7:0] msk,
                     input bit set, input bit wide, input logic [15:0] off,
                     input logic [15:0] addr, input logic [3:0] pg, input logic [3:0] len);
    logic [20:0] exp_w, act_w;
    @(negedge clk_i);
    mem_byte_i = mem; mask_i = msk; test_set_i = set; wide_off_i = wide;
    offset_i = off; insn_addr_i = addr; page_i = pg; insn_len_i = len; start_i = 1'b1;
    model();
    @(negedge clk_i);
    start_i = 1'b0;
    exp_w = {1'b1, m_taken, m_page[3:0], m_pc[15:0]} >> 0;
    exp_w = {valid_o ? 1'b0 : 1'b0, 20'h0};
    act_w = {taken_o, page_o, pc_o};
    exp_w = {m_taken, m_page[3:0], m_pc[15:0]};
    check(valid_o == 1'b1, "R9", "valid", 32'(valid_o), 32'd1);
    check(act_w == exp_w, tag, "taken/page/pc", 32'(act_w), 32'(exp_w));
    mem_byte_i = ~mem; mask_i = 8'hFF; offset_i = ~off; page_i = ~pg; insn_addr_i = ~addr;
    @(negedge clk_i);
    check(valid_o == 1'b0 && {taken_o, page_o, pc_o} == exp_w, "R9", "idle hold",
          32'({valid_o, taken_o, page_o, pc_o}), 32'(exp_w));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({valid_o, taken_o, page_o, pc_o} == 22'h0, "R10", "reset state",
          32'({valid_o, taken_o, page_o, pc_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    vec("R1", 8'hF0, 8'h0F, 1'b0, 1'b0, 16'h0010, 16'h1000, 4'h2, 4'h4);
    vec("R1", 8'h01, 8'h03, 1'b0, 1'b0, 16'h0010, 16'h1000, 4'h2, 4'h4);
    vec("R8", 8'h40, 8'h40, 1'b0, 1'b0, 16'h0020, 16'h2001, 4'h1, 4'h3);
    vec("R2", 8'hFF, 8'h81, 1'b1, 1'b0, 16'h0008, 16'h3000, 4'h0, 4'h4);
    vec("R2", 8'h7F, 8'h80, 1'b1, 1'b0, 16'h0008, 16'h3000, 4'h0, 4'h4);
    vec("R2", 8'hEF, 8'hFF, 1'b1, 1'b1, 16'h0100, 16'h3000, 4'h0, 4'h6);
    vec("R3", 8'hA5, 8'h00, 1'b0, 1'b0, 16'h0002, 16'h4000, 4'h7, 4'h4);
    vec("R3", 8'hA5, 8'h00, 1'b1, 1'b0, 16'h0002, 16'h4000, 4'h7, 4'h4);
    vec("R6", 8'h00, 8'hFF, 1'b0, 1'b0, 16'h007F, 16'h5000, 4'h3, 4'h4);
    vec("R6", 8'h00, 8'hFF, 1'b0, 1'b0, 16'h0080, 16'h5000, 4'h3, 4'h4);
    vec("R6", 8'h00, 8'hFF, 1'b0, 1'b1, 16'h7FFF, 16'h5000, 4'h3, 4'h6);
    vec("R6", 8'h00, 8'hFF, 1'b0, 1'b1, 16'h8000, 16'h9000, 4'h3, 4'h6);
    vec("R4", 8'h00, 8'hFF, 1'b0, 1'b0, 16'hAB05, 16'h6000, 4'h1, 4'h4);
    vec("R4", 8'h00, 8'hFF, 1'b0, 1'b0, 16'h01F0, 16'h6000, 4'h1, 4'h4);
    vec("R5", 8'h00, 8'hFF, 1'b0, 1'b0, 16'h00FD, 16'h7002, 4'h1, 4'h4);
    vec("R5", 8'h00, 8'hFF, 1'b0, 1'b1, 16'h0333, 16'h7002, 4'h1, 4'h4);
    vec("R7", 8'h00, 8'hFF, 1'b0, 1'b0, 16'h0020, 16'hFFF0, 4'h3, 4'h4);
    vec("R7", 8'h00, 8'hFF, 1'b0, 1'b0, 16'h00F0, 16'h0004, 4'h3, 4'h4);
    vec("R7", 8'h00, 8'hFF, 1'b0, 1'b1, 16'h7FFE, 16'hC000, 4'hF, 4'h4);
    vec("R7", 8'h00, 8'hFF, 1'b0, 1'b1, 16'h8000, 16'h0010, 4'h0, 4'h4);
    vec("R8", 8'hFF, 8'h01, 1'b0, 1'b0, 16'h0040, 16'hFFFE, 4'h5, 4'h4);
    vec("R8", 8'hFF, 8'h01, 1'b0, 1'b0, 16'h0040, 16'hFFFD, 4'hF, 4'hF);

    // back-to-back starts: valid stays high, each result lands in turn
    @(negedge clk_i);
    mem_byte_i = 8'h00; mask_i = 8'hFF; test_set_i = 1'b0; wide_off_i = 1'b0;
    offset_i = 16'h0010; insn_addr_i = 16'h0100; page_i = 4'h2; insn_len_i = 4'h4;
    start_i = 1'b1;
    model();
    @(negedge clk_i);
    check(valid_o && {taken_o, page_o, pc_o} == {m_taken, m_page[3:0], m_pc[15:0]}, "R9",
          "b2b first", 32'({valid_o, taken_o, page_o, pc_o}),
          32'({1'b1, m_taken, m_page[3:0], m_pc[15:0]}));
    mem_byte_i = 8'h01; mask_i = 8'h01; test_set_i = 1'b0;
    model();
    @(negedge clk_i);
    start_i = 1'b0;
    check(valid_o && {taken_o, page_o, pc_o} == {m_taken, m_page[3:0], m_pc[15:0]}, "R9",
          "b2b second", 32'({valid_o, taken_o, page_o, pc_o}),
          32'({1'b1, m_taken, m_page[3:0], m_pc[15:0]}));
    @(negedge clk_i);
    check(!valid_o, "R9", "valid drop", 32'(valid_o), 32'd0);

    // reset mid-run clears outputs
    rst_ni = 1'b0;
    @(negedge clk_i);
    check({valid_o, taken_o, page_o, pc_o} == 22'h0, "R10", "re-reset",
          32'({valid_o, taken_o, page_o, pc_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    done = 1'b1;
    finish_run();
  end
endmodule